// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block is a square grid of multiply-accumulate cells that computes y = W·x for a stream of input vectors. Each cell keeps one weight. A shift port loads these weights one row per cycle before a batch starts. Each accepted input vector is skewed at the array edge, so element j reaches column j one cycle after element j-1. Input values then travel down the rows, one row per cycle. Partial sums travel across each row toward the last column, so the right edge of row r delivers the finished dot product of weight row r with the vector.

Operands are 8-bit signed integers. The products and all partial sums are 32-bit signed, so a dot product never wraps for N up to 128. Every result leaves the array with a valid flag, and with the index of its vector within the current batch. Results appear skewed in time: row r of a vector comes out one cycle after row r-1 of the same vector. A cycle with no valid input goes through the array as an empty slot and produces no result.

Top module: `sa_matmul`

## Requirements
- R1: During reset and right after it, out_valid is all zero, and out_y and out_idx are zero.
- R2: Each cycle with ld_en high shifts the stored weight rows down by one. ld_row goes into row 0, and row r takes the old row r-1. Field j of ld_row (bits j*8 upward) is the weight for column j. After N consecutive loads, the row presented first sits in row N-1 and the row presented last sits in row 0. Weights do not change while ld_en is low.
- R3: For every accepted vector, row r of out_y (bits r*32 upward) equals the sum over j of W(r,j)·x(j). Field j of in_vec (bits j*8 upward) is x(j). The operands are 8-bit signed and the result is 32-bit signed.
- R4: A vector sampled on clock edge E gives its row r result on out_valid[r] right after edge E+N-1+r. Row r+1 always follows row r by exactly one cycle.
- R5: Vectors may be applied on consecutive cycles with no gap. Every accepted vector gives exactly one result per row, and results within a row come out in the order the vectors were accepted.
- R6: out_idx field r (bits r*IW upward) carries the index of the vector within its batch. A start pulse opens a batch: a vector accepted in the start cycle gets index 0, or, if that cycle has no vector, the next accepted vector gets index 0. Each later accepted vector gets the previous index plus one, modulo 2^IW. Start must not be raised while ld_en is high.
- R7: A cycle with in_valid low produces no result in any row. Whenever out_valid[r] is low, row r of out_y reads zero. Such an empty slot does not disturb the results of its neighbours.
- R8: Extreme operands give exact results, with no overflow: N·(−128)·(−128) and N·(−128)·127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Shift ld_row into weight row 0 this cycle |
| ld_row | input | N*8 | One row of signed weights, field j for column j |
| start | input | 1 | Begin a new batch, restarting the vector index |
| in_valid | input | 1 | in_vec holds a vector this cycle |
| in_vec | input | N*8 | Signed input vector, field j is element j |
| out_valid | output | N | Per-row result flag |
| out_idx | output | N*IW | Per-row vector index within the batch |
| out_y | output | N*32 | Per-row signed dot product |

## Verification
The hardest case to bring about is a mix of empty slots and back-to-back vectors. In this case one row is still returning the last vectors of a batch while the input edge already carries the next vectors. On top of that, a start pulse can land on an empty cycle, and the index can wrap. The stimulus reaches this case with pseudo-random valid patterns over batches longer than the index range. Some of these batches open with start on an empty cycle. It also sweeps several pseudo-random weight sets and a set made only of extreme values. The bench predicts each expected result, its index and its arrival cycle when the vector is driven, and matches them row by row as results come out.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int OPW  = 8;
  localparam int ACCW = 32;

  typedef logic signed [OPW-1:0]  opnd_t;
  typedef logic signed [ACCW-1:0] acc_t;

  // one cell step: narrow signed product widened into the running sum
  function automatic acc_t mac_step(acc_t ps, opnd_t w, opnd_t x);
    logic signed [2*OPW-1:0] prod;
    prod = w * x;
    return ps + acc_t'(prod);
  endfunction
endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < DEPTH; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[DEPTH-1];
endmodule

// File: rtl/sa_wbank.sv
module sa_wbank import sa_pkg::*; #(
  parameter int N = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  opnd_t row_in [N],
  output opnd_t wt [N][N]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int j = 0; j < N; j++) wt[r][j] <= '0;
    end else if (ld_en) begin
      for (int j = 0; j < N; j++) wt[0][j] <= row_in[j];
      for (int r = 1; r < N; r++)
        for (int j = 0; j < N; j++) wt[r][j] <= wt[r-1][j];
    end
  end
endmodule

// File: rtl/sa_cell.sv
module sa_cell import sa_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  opnd_t w,
  input  opnd_t x,
  input  logic  v,
  input  acc_t  ps_in,
  output acc_t  ps_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ps_out <= '0;
    else if (v)  ps_out <= mac_step(ps_in, w, x);
    else         ps_out <= '0;
  end
endmodule

// File: rtl/sa_matmul.sv
module sa_matmul import sa_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [N*OPW-1:0]  ld_row,
  input  logic              start,
  input  logic              in_valid,
  input  logic [N*OPW-1:0]  in_vec,
  output logic [N-1:0]      out_valid,
  output logic [N*IW-1:0]   out_idx,
  output logic [N*ACCW-1:0] out_y
);
  localparam int SKW = OPW + 1;

  opnd_t          ld_u [N];
  opnd_t          x_u  [N];
  logic [IW-1:0]  cnt_q;
  logic [IW-1:0]  acc_idx;
  logic [IW-1:0]  tag0;
  logic [SKW-1:0] sk_q [N];
  opnd_t          wt   [N][N];
  opnd_t          xin  [N][N];
  logic           vin  [N][N];
  logic [IW-1:0]  tin  [N];
  opnd_t          xp   [1:N-1][N];
  logic           vp   [1:N-1][N];
  logic [IW-1:0]  tp   [1:N-1];
  acc_t           ps   [N][N];

  // edge unpacking; an empty slot enters as zero
  for (genvar j = 0; j < N; j++) begin : g_unpack
    assign ld_u[j] = ld_row[j*OPW +: OPW];
    assign x_u[j]  = in_valid ? opnd_t'(in_vec[j*OPW +: OPW]) : '0;
  end

  // batch index counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (start)    cnt_q <= in_valid ? IW'(1) : '0;
    else if (in_valid) cnt_q <= cnt_q + IW'(1);
  end
  assign acc_idx = start ? '0 : cnt_q;

  // diagonal skew: column j waits j cycles
  for (genvar j = 0; j < N; j++) begin : g_skew
    if (j == 0) begin : g_direct
      assign sk_q[j] = {in_valid, x_u[j]};
    end else begin : g_line
      sa_delay #(.WIDTH(SKW), .DEPTH(j)) u_dl (
        .clk(clk), .rst_n(rst_n), .d({in_valid, x_u[j]}), .q(sk_q[j])
      );
    end
  end

  // the index rides with the last column only
  sa_delay #(.WIDTH(IW), .DEPTH(N-1)) u_tag (
    .clk(clk), .rst_n(rst_n), .d(acc_idx), .q(tag0)
  );

  // stationary weights
  sa_wbank #(.N(N)) u_wbank (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .row_in(ld_u), .wt(wt)
  );

  // row inputs: row 0 from the skew, row r from the registers of row r-1
  always_comb begin
    for (int j = 0; j < N; j++) begin
      vin[0][j] = sk_q[j][SKW-1];
      xin[0][j] = opnd_t'(sk_q[j][OPW-1:0]);
    end
    tin[0] = tag0;
    for (int r = 1; r < N; r++) begin
      for (int j = 0; j < N; j++) begin
        xin[r][j] = xp[r][j];
        vin[r][j] = vp[r][j];
      end
      tin[r] = tp[r];
    end
  end

  // downward ripple of inputs, valid and index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 1; r < N; r++) begin
        for (int j = 0; j < N; j++) begin
          xp[r][j] <= '0;
          vp[r][j] <= 1'b0;
        end
        tp[r] <= '0;
      end
    end else begin
      for (int r = 1; r < N; r++) begin
        for (int j = 0; j < N; j++) begin
          xp[r][j] <= xin[r-1][j];
          vp[r][j] <= vin[r-1][j];
        end
        tp[r] <= tin[r-1];
      end
    end
  end

  // cell grid; partial sums move toward the last column
  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      acc_t ps_left;
      if (j == 0) begin : g_first
        assign ps_left = '0;
      end else begin : g_chain
        assign ps_left = ps[r][j-1];
      end
      sa_cell u_cell (
        .clk(clk), .rst_n(rst_n), .w(wt[r][j]), .x(xin[r][j]),
        .v(vin[r][j]), .ps_in(ps_left), .ps_out(ps[r][j])
      );
    end
    assign out_y[r*ACCW +: ACCW] = ps[r][N-1];
  end

  // flags aligned with the last-column sum registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_idx   <= '0;
    end else begin
      for (int r = 0; r < N; r++) begin
        out_valid[r]           <= vin[r][N-1];
        out_idx[r*IW +: IW]    <= tin[r];
      end
    end
  end
endmodule

// File: rtl/sa_matmul_chk.sv
module sa_matmul_chk import sa_pkg::*; #(
  parameter int N  = 4,
  parameter int IW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic              start,
  input logic [N-1:0]      out_valid,
  input logic [N*IW-1:0]   out_idx,
  input logic [N*ACCW-1:0] out_y
);
  localparam longint LIM = longint'(N) * (longint'(1) << (2*OPW-2));

  a_r6_no_start_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_en && start));

  for (genvar r = 0; r < N; r++) begin : g_row
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[r] |-> out_y[r*ACCW +: ACCW] == '0);
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[r] |-> (longint'($signed(out_y[r*ACCW +: ACCW])) <= LIM &&
                        longint'($signed(out_y[r*ACCW +: ACCW])) >= -LIM));
    if (r < N-1) begin : g_lag
      a_r4_row_lag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[r] |=> out_valid[r+1]);
      a_r5_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[r+1] |-> $past(out_valid[r]));
      a_r6_idx_follow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[r+1] |-> out_idx[(r+1)*IW +: IW] == $past(out_idx[r*IW +: IW]));
    end
  end
endmodule

bind sa_matmul sa_matmul_chk #(.N(N), .IW(IW)) u_chk (.*);

// File: tb/test_sa_matmul.sv
module test_sa_matmul;
  localparam int N  = 3;
  localparam int IW = 4;
  localparam int MX = 1024;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_en = 1'b0;
  logic [N*8-1:0]  ld_row = '0;
  logic            start = 1'b0;
  logic            in_valid = 1'b0;
  logic [N*8-1:0]  in_vec = '0;
  logic [N-1:0]    out_valid;
  logic [N*IW-1:0] out_idx;
  logic [N*32-1:0] out_y;

  sa_matmul #(.N(N), .IW(IW)) i_sa_matmul (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_row(ld_row), .start(start),
    .in_valid(in_valid), .in_vec(in_vec), .out_valid(out_valid),
    .out_idx(out_idx), .out_y(out_y)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, tick = 0;
  int wm [N][N];
  int exp_y [MX][N];
  int exp_i [MX];
  int exp_t [MX];
  string rq [MX];
  int nseq = 0, cnt_m = 0;
  int rp [N];
  bit mon_on = 1'b0, fin = 1'b0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF) - 128;
  endfunction

  always @(posedge clk) begin
    tick <= tick + 1;
    if (tick > 150000 && !fin) begin
      fin = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // weight row model: shift down, new row enters row 0 (R2)
  task automatic load_row(input int a, input int b, input int c);
    @(negedge clk);
    ld_en = 1'b1; start = 1'b0; in_valid = 1'b0;
    ld_row = {8'(c), 8'(b), 8'(a)};
    for (int r = N-1; r > 0; r--)
      for (int j = 0; j < N; j++) wm[r][j] = wm[r-1][j];
    wm[0][0] = a; wm[0][1] = b; wm[0][2] = c;
  endtask

  task automatic send(input bit st, input bit v, input int a, input int b,
                      input int c, input string req);
    int xs [N];
    @(negedge clk);
    ld_en = 1'b0; start = st; in_valid = v;
    in_vec = {8'(c), 8'(b), 8'(a)};
    xs[0] = a; xs[1] = b; xs[2] = c;
    if (st) cnt_m = 0;
    if (v) begin
      exp_i[nseq] = cnt_m % (1 << IW);
      exp_t[nseq] = tick;
      rq[nseq] = req;
      for (int r = 0; r < N; r++) begin
        exp_y[nseq][r] = 0;
        for (int j = 0; j < N; j++) exp_y[nseq][r] += wm[r][j] * xs[j];
      end
      nseq++;
      cnt_m++;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ld_en = 1'b0; start = 1'b0; in_valid = 1'b0;
    end
  endtask

  // result scoreboard, sampled away from the rising edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      for (int r = 0; r < N; r++) begin
        if (out_valid[r]) begin
          if (rp[r] >= nseq) begin
            chk(1'b0, "R7 unexpected result", r, -1);
          end else begin
            chk(int'($signed(out_y[r*32 +: 32])) == exp_y[rp[r]][r], rq[rp[r]],
                int'($signed(out_y[r*32 +: 32])), exp_y[rp[r]][r]);
            chk(int'(out_idx[r*IW +: IW]) == exp_i[rp[r]], "R6 index",
                int'(out_idx[r*IW +: IW]), exp_i[rp[r]]);
            chk(tick == exp_t[rp[r]] + N + r, "R4 R5 arrival tick",
                tick, exp_t[rp[r]] + N + r);
            rp[r]++;
          end
        end else begin
          chk(out_y[r*32 +: 32] == '0, "R7 idle row zero",
              int'($signed(out_y[r*32 +: 32])), 0);
        end
      end
    end
  end

  initial begin
    for (int r = 0; r < N; r++) begin
      rp[r] = 0;
      for (int j = 0; j < N; j++) wm[r][j] = 0;
    end
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1 valid in reset", out_valid, 0);
    chk(out_y == '0, "R1 y in reset", 0, 0);
    chk(out_idx == '0, "R1 idx in reset", out_idx, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1 valid after reset", out_valid, 0);

    // first row presented lands in row N-1 (R2)
    load_row(7, -8, 9);
    load_row(-4, 5, -6);
    load_row(1, -2, 3);
    idle(2);
    send(1'b1, 1'b1, 1, 0, 0, "R2 column 0");
    send(1'b0, 1'b1, 0, 1, 0, "R2 column 1");
    send(1'b0, 1'b1, 0, 0, 1, "R2 column 2");
    send(1'b0, 1'b1, 1, 2, 3, "R3 dot");
    send(1'b0, 1'b1, -4, 5, -6, "R3 dot");
    send(1'b0, 1'b1, 7, -8, 127, "R3 dot");
    idle(2*N + 4);

    // pseudo-random weights, bubbly back-to-back batches (R3 R5 R6 R7)
    for (int s = 1; s <= 6; s++) begin
      for (int k = 0; k < N; k++) load_row(rnd8(), rnd8(), rnd8());
      idle(1);
      for (int t = 0; t < 40; t++) begin
        bit v;
        v = (rnd8() > -64) && !(t == 0 && (s % 2 == 0));
        send(t == 0, v, rnd8(), rnd8(), rnd8(), "R3 R7 sweep");
      end
      // a second batch opens while the first is still draining
      send(1'b1, 1'b0, 0, 0, 0, "R6");
      for (int t = 0; t < 5; t++) send(1'b0, 1'b1, rnd8(), rnd8(), rnd8(), "R6 R3 restart");
      idle(2*N + 4);
    end

    // extreme operands (R8)
    load_row(-128, -128, -128);
    load_row(-128, -128, -128);
    load_row(-128, -128, 127);
    idle(1);
    send(1'b1, 1'b1, -128, -128, -128, "R8 extreme");
    send(1'b0, 1'b1, 127, 127, 127, "R8 extreme");
    send(1'b0, 1'b1, -128, 127, -128, "R8 extreme");
    idle(2*N + 6);

    for (int r = 0; r < N; r++) chk(rp[r] == nseq, "R5 all delivered", rp[r], nseq);
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule